// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block is a synchronous master for an asynchronous byte-wide flash bus. A client hands it one request: an operation type, a start address and, for programming, a byte count. The block then drives the flash address, data, chip-enable, output-enable and write-enable lines itself. It issues the unlock write cycles, issues the operation command, and then reads the device again and again until the device reports that the internal operation has finished.

Programming pulls one byte at a time from a valid/ready data stream. After each byte has been confirmed, the block moves to the next address. Erase covers a sector, a block or the whole chip and is checked once at its end. Every strobe width and every gap between strobes is a whole number of controller clock cycles, set by parameters. The strobes are registered, so no pulse can be shorter than one clock. A run-time poll limit ends an operation whose device never reports completion and raises an error flag.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Operation code 0 programs bytes. For each byte the block writes exactly four bus cycles, in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then the data byte at the target address.
- R2: Operation codes 1 (sector), 2 (block) and 3 (chip) erase. Each writes six bus cycles: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then a final cycle. The final cycle is 30h at the request address for a sector, 50h at the request address for a block, and 10h at 555h for the chip.
- R3: Each write holds write-enable and chip-enable low for exactly WP_CYC clock cycles. The block leaves at least GAP_CYC cycles with every strobe high between any two strobes.
- R4: The address and the write data do not change while write-enable is low, nor in the cycle after it rises.
- R5: Each status read holds output-enable and chip-enable low for exactly RD_CYC cycles, with write-enable high and the data bus not driven (fl_drive low). Write-enable and output-enable are never low together.
- R6: After a byte is programmed, polling ends on the first read whose bit 7 equals bit 7 of the written byte. It also ends on the first read whose bit 6 equals bit 6 of the read just before it.
- R7: After an erase, polling ends on the first read equal to FFh, or on the first read whose bit 6 equals bit 6 of the previous read.
- R8: A program request with length field L writes L+1 bytes at consecutive addresses, starting at the request address. The block takes exactly one data byte per byte programmed, and asks for data only during program operations.
- R9: When poll_limit reads have passed without completion, the operation ends with done and err both high. Any remaining bytes are neither fetched nor written. A limit of 0 acts as 1.
- R10: done is high for one cycle at the end of every operation, with err low on success. busy is high from acceptance until that cycle. req_ready is high only while the block is idle.
- R11: After reset all strobes are high, the data bus is not driven, busy and done are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Start address, or the address of the sector or block |
| req_len_m1 | input | LW | Number of bytes to program, minus one |
| poll_limit | input | TW | Maximum number of status reads per poll |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Block takes the byte this cycle |
| wr_byte | input | 8 | Program data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Poll limit reached (valid with done) |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data driven onto the flash bus |
| fl_drive | output | 1 | Output enable for the data pins |
| fl_din | input | 8 | Data read from the flash bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The bench checks that the address and data captured at each write strobe match the expected command sequence, byte for byte. A wrong step index or a wrong operation code therefore shows up as a mismatch at the very first write strobe it affects. A fault in the cycle counters shows up as a strobe width or gap that is off by some cycles, and the bench flags it when that strobe rises. A poll decision that is wrong shows up, within one read, as a read count that differs from the busy pattern the flash model was given. It can also show up as a false error flag, or as a data byte fetched too early or left unfetched.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SECTOR = 2'd1,
        OP_BLOCK  = 2'd2,
        OP_CHIP   = 2'd3
    } op_e;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CMD, S_CMDW, S_POLL, S_POLLW} seq_e;

    // address source for one command write
    typedef enum logic [1:0] {A_KEY1, A_KEY2, A_TGT} asel_e;

    typedef struct packed {
        asel_e      asel;
        logic [7:0] data;
    } cmd_t;

    function automatic logic [2:0] final_step(op_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

    function automatic cmd_t cmd_at(op_e op, logic [2:0] idx, logic [7:0] val);
        cmd_t c;
        c.asel = A_KEY1;
        c.data = 8'hAA;
        case (idx)
            3'd0: begin c.asel = A_KEY1; c.data = 8'hAA; end
            3'd1: begin c.asel = A_KEY2; c.data = 8'h55; end
            3'd2: begin c.asel = A_KEY1; c.data = (op == OP_PROG) ? 8'hA0 : 8'h80; end
            3'd3: begin
                if (op == OP_PROG) begin c.asel = A_TGT; c.data = val; end
                else begin c.asel = A_KEY1; c.data = 8'hAA; end
            end
            3'd4: begin c.asel = A_KEY2; c.data = 8'h55; end
            default: begin
                case (op)
                    OP_CHIP:   begin c.asel = A_KEY1; c.data = 8'h10; end
                    OP_SECTOR: begin c.asel = A_TGT;  c.data = 8'h30; end
                    default:   begin c.asel = A_TGT;  c.data = 8'h50; end
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flash_poll_judge.sv
module flash_poll_judge (
    input  logic       is_erase,
    input  logic       want_b7,
    input  logic [7:0] rd,
    input  logic       prev6,
    input  logic       have_prev,
    output logic       complete
);
    logic toggle_stopped;
    logic data_match;

    always_comb begin
        toggle_stopped = have_prev && (rd[6] == prev6);
        data_match     = is_erase ? (rd == 8'hFF) : (rd[7] == want_b7);
        complete       = toggle_stopped || data_match;
    end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_prog_pkg::*;
#(
    parameter int AW      = 18,
    parameter int WP_CYC  = 5,
    parameter int GAP_CYC = 4,
    parameter int RD_CYC  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_wr,
    input  logic [AW-1:0] go_addr,
    input  logic [7:0]    go_data,
    output logic          ready,
    output logic          fin,
    output logic [7:0]    rd_byte,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dout,
    output logic          fl_drive,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    input  logic [7:0]    fl_din
);
    localparam int MAX_SR = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
    localparam int MAXC   = (MAX_SR > GAP_CYC) ? MAX_SR : GAP_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          wr;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    rd;
        logic          fin;
        logic          drive;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (go) begin
                    d.ph    = PH_SETUP;
                    d.wr    = go_wr;
                    d.addr  = go_addr;
                    d.data  = go_data;
                    d.drive = go_wr;
                    d.cnt   = '0;
                end
            end
            PH_SETUP: begin
                d.ph   = PH_STROBE;
                d.ce_n = 1'b0;
                d.we_n = ~q.wr;
                d.oe_n = q.wr;
                d.cnt  = CW'(1);
            end
            PH_STROBE: begin
                if (q.cnt == (q.wr ? CW'(WP_CYC) : CW'(RD_CYC))) begin
                    if (!q.wr) d.rd = fl_din;
                    d.ce_n = 1'b1;
                    d.we_n = 1'b1;
                    d.oe_n = 1'b1;
                    d.ph   = PH_HOLD;
                    d.cnt  = CW'(1);
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: begin
                if (q.cnt == CW'(GAP_CYC)) begin
                    d.ph    = PH_IDLE;
                    d.drive = 1'b0;
                    d.fin   = 1'b1;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, cnt: '0, wr: 1'b0, addr: '0, data: '0, rd: '0,
                   fin: 1'b0, drive: 1'b0, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign ready    = (q.ph == PH_IDLE);
    assign fin      = q.fin;
    assign rd_byte  = q.rd;
    assign fl_addr  = q.addr;
    assign fl_dout  = q.data;
    assign fl_drive = q.drive;
    assign fl_ce_n  = q.ce_n;
    assign fl_we_n  = q.we_n;
    assign fl_oe_n  = q.oe_n;

    // checker: length of the current write-enable low run
    logic [7:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run_q <= '0;
        else if (!fl_we_n) low_run_q <= low_run_q + 8'd1;
        else               low_run_q <= '0;
    end

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (low_run_q == 8'(WP_CYC))); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> ($stable(fl_addr) && $stable(fl_dout))); // R4
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n)); // R5
    AST_READ_NODRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_drive); // R5
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int AW      = 18,
    parameter int LW      = 16,
    parameter int TW      = 16,
    parameter int WP_CYC  = 5,
    parameter int GAP_CYC = 4,
    parameter int RD_CYC  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len_m1,
    input  logic [TW-1:0] poll_limit,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [7:0]    wr_byte,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dout,
    output logic          fl_drive,
    input  logic [7:0]    fl_din,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam logic [AW-1:0] KEY1_ADDR = AW'(12'h555);
    localparam logic [AW-1:0] KEY2_ADDR = AW'(12'h2AA);

    typedef struct packed {
        seq_e          st;
        op_e           op;
        logic [AW-1:0] addr;
        logic [LW-1:0] remain;
        logic [7:0]    val;
        logic [2:0]    idx;
        logic [TW-1:0] polls;
        logic          prev6;
        logic          have_prev;
        logic          done;
        logic          err;
    } seq_t;

    seq_t q, d;

    logic          eng_go, eng_go_wr, eng_ready, eng_fin, poll_ok;
    logic [AW-1:0] eng_addr;
    logic [7:0]    eng_data, eng_rd;
    cmd_t          cmd;
    logic [TW:0]   polls_next;

    flash_poll_judge u_judge (
        .is_erase  (q.op != OP_PROG),
        .want_b7   (q.val[7]),
        .rd        (eng_rd),
        .prev6     (q.prev6),
        .have_prev (q.have_prev),
        .complete  (poll_ok)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.err      = 1'b0;
        req_ready  = 1'b0;
        wr_ready   = 1'b0;
        eng_go     = 1'b0;
        eng_go_wr  = 1'b0;
        eng_data   = 8'h00;
        eng_addr   = q.addr;
        cmd        = cmd_at(q.op, q.idx, q.val);
        polls_next = {1'b0, q.polls} + 1'b1;
        case (q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.op     = op_e'(req_op);
                    d.addr   = req_addr;
                    d.remain = req_len_m1;
                    d.idx    = '0;
                    d.st     = (op_e'(req_op) == OP_PROG) ? S_FETCH : S_CMD;
                end
            end
            S_FETCH: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    d.val = wr_byte;
                    d.idx = '0;
                    d.st  = S_CMD;
                end
            end
            S_CMD: begin
                eng_go    = eng_ready;
                eng_go_wr = 1'b1;
                eng_data  = cmd.data;
                case (cmd.asel)
                    A_KEY1:  eng_addr = KEY1_ADDR;
                    A_KEY2:  eng_addr = KEY2_ADDR;
                    default: eng_addr = q.addr;
                endcase
                if (eng_ready) d.st = S_CMDW;
            end
            S_CMDW: begin
                if (eng_fin) begin
                    if (q.idx == final_step(q.op)) begin
                        d.st        = S_POLL;
                        d.polls     = '0;
                        d.have_prev = 1'b0;
                    end else begin
                        d.idx = q.idx + 3'd1;
                        d.st  = S_CMD;
                    end
                end
            end
            S_POLL: begin
                eng_go = eng_ready;
                if (eng_ready) d.st = S_POLLW;
            end
            default: begin
                if (eng_fin) begin
                    d.polls = polls_next[TW-1:0];
                    if (poll_ok) begin
                        if (q.op != OP_PROG || q.remain == '0) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.remain = q.remain - 1'b1;
                            d.addr   = q.addr + 1'b1;
                            d.st     = S_FETCH;
                        end
                    end else if (polls_next >= {1'b0, poll_limit}) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.prev6     = eng_rd[6];
                        d.have_prev = 1'b1;
                        d.st        = S_POLL;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, op: OP_PROG, addr: '0, remain: '0, val: '0, idx: '0,
                   polls: '0, prev6: 1'b0, have_prev: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != S_IDLE);
    assign done = q.done;
    assign err  = q.err;

    flash_bus_cycle #(
        .AW(AW), .WP_CYC(WP_CYC), .GAP_CYC(GAP_CYC), .RD_CYC(RD_CYC)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (eng_go),
        .go_wr    (eng_go_wr),
        .go_addr  (eng_addr),
        .go_data  (eng_data),
        .ready    (eng_ready),
        .fin      (eng_fin),
        .rd_byte  (eng_rd),
        .fl_addr  (fl_addr),
        .fl_dout  (fl_dout),
        .fl_drive (fl_drive),
        .fl_ce_n  (fl_ce_n),
        .fl_we_n  (fl_we_n),
        .fl_oe_n  (fl_oe_n),
        .fl_din   (fl_din)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy); // R10
    AST_FETCH_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (q.op == OP_PROG)); // R8
endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
    localparam int AW = 18, LW = 16, TW = 16;
    localparam int WP = 5, GAP = 4, RD = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len_m1 = '0;
    logic [TW-1:0] poll_limit = 16'd100;
    logic wr_valid = 1'b0, wr_ready;
    logic [7:0] wr_byte = 8'h00;
    logic busy, done, err;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dout;
    logic fl_drive;
    logic [7:0] fl_din = 8'h00;
    logic fl_ce_n, fl_oe_n, fl_we_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_prog_ctrl #(.AW(AW), .LW(LW), .TW(TW), .WP_CYC(WP), .GAP_CYC(GAP), .RD_CYC(RD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len_m1(req_len_m1),
        .poll_limit(poll_limit), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_byte(wr_byte), .busy(busy), .done(done), .err(err),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_drive(fl_drive), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard of expected bus writes
    int         exp_a[$];
    logic [7:0] exp_d[$];
    logic [7:0] data_q[$];
    string      cur_tag = "R1";

    // flash model state
    int         m_mode = 0;      // 0 normal, 1 toggle stops, 2 never finishes
    int         m_busy_cfg = 0, m_busy = 0;
    int         arm_cfg = 4, arm_left = 4;
    bit         m_erase = 1'b0;
    logic [7:0] m_last = 8'h00;
    logic       m_tog = 1'b0, m_last6 = 1'b0;
    int         reads = 0, consumed = 0;

    // monitor of the flash bus
    logic       we_p = 1'b1, oe_p = 1'b1;
    int         we_low = 0, oe_low = 0, hi_run = 0;
    bit         seen_strobe = 1'b0;
    logic [AW-1:0] lat_a;
    logic [7:0] lat_d;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((we_p && !fl_we_n) || (oe_p && !fl_oe_n)) begin
                if (seen_strobe) chk(hi_run >= GAP, "R3", "strobe gap", hi_run, GAP);
                seen_strobe = 1'b1;
            end
            if (we_p && !fl_we_n) begin
                lat_a = fl_addr; lat_d = fl_dout; we_low = 0;
                chk(!fl_ce_n, "R3", "ce low with we", fl_ce_n, 0);
            end
            if (oe_p && !fl_oe_n) begin
                logic [7:0] resp;
                oe_low = 0;
                reads++;
                chk(!fl_drive && fl_we_n && !fl_ce_n, "R5", "read bus state",
                    {fl_drive, fl_we_n, fl_ce_n}, 3'b010);
                if (m_mode == 2 || m_busy > 0) begin
                    resp = {~m_last[7], m_tog, 6'h15};
                    m_tog = ~m_tog;
                    if (m_busy > 0) m_busy--;
                end else if (m_mode == 1) begin
                    resp = {~m_last[7], m_last6, 6'h15};
                end else begin
                    resp = m_last;
                end
                m_last6 = resp[6];
                fl_din = resp;
            end
            if (!fl_we_n) we_low++;
            if (!fl_oe_n) oe_low++;
            if (fl_we_n && fl_oe_n) hi_run++; else hi_run = 0;
            if (!we_p && fl_we_n) begin
                chk(we_low == WP, "R3", "we low width", we_low, WP);
                chk(lat_a == fl_addr && lat_d == fl_dout, "R4", "addr/data hold",
                    {fl_addr, fl_dout}, {lat_a, lat_d});
                if (exp_a.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected write", {fl_addr, fl_dout}, 0);
                end else begin
                    int         ea;
                    logic [7:0] ed;
                    ea = exp_a.pop_front();
                    ed = exp_d.pop_front();
                    chk(int'(fl_addr) == ea, cur_tag, "write address", fl_addr, ea);
                    chk(fl_dout == ed, cur_tag, "write data", fl_dout, ed);
                end
                arm_left--;
                if (arm_left == 0) begin
                    arm_left = arm_cfg;
                    m_busy = m_busy_cfg;
                    m_tog = 1'b0;
                    m_last = m_erase ? 8'hFF : fl_dout;
                end
            end
            if (!oe_p && fl_oe_n) chk(oe_low == RD, "R5", "oe low width", oe_low, RD);
            we_p = fl_we_n;
            oe_p = fl_oe_n;
        end
    end

    // data stream driver
    initial begin
        bit took;
        forever begin
            @(negedge clk);
            took = wr_valid && wr_ready;
            @(posedge clk);
            #1;
            if (took) begin
                void'(data_q.pop_front());
                consumed++;
            end
            wr_valid = (data_q.size() > 0);
            wr_byte  = (data_q.size() > 0) ? data_q[0] : 8'h00;
        end
    end

    task automatic push_w(input int a, input logic [7:0] dv);
        exp_a.push_back(a);
        exp_d.push_back(dv);
    endtask

    task automatic run_op(input logic [1:0] op, input int addr, input int len_m1, input int mode,
                          input int busyk, input int limit, input bit exp_err,
                          input int exp_reads, input int exp_bytes, input string tag);
        int n;
        bit got_done;
        bit got_err;
        cur_tag = tag;
        m_mode = mode; m_busy_cfg = busyk; m_busy = 0;
        m_erase = (op != 2'd0);
        arm_cfg = (op == 2'd0) ? 4 : 6;
        arm_left = arm_cfg;
        reads = 0; consumed = 0;
        if (op == 2'd0) begin
            for (int i = 0; i < exp_bytes; i++) begin
                push_w(12'h555, 8'hAA); push_w(12'h2AA, 8'h55); push_w(12'h555, 8'hA0);
                push_w(addr + i, data_q[i]);
            end
        end else begin
            push_w(12'h555, 8'hAA); push_w(12'h2AA, 8'h55); push_w(12'h555, 8'h80);
            push_w(12'h555, 8'hAA); push_w(12'h2AA, 8'h55);
            if (op == 2'd3)      push_w(12'h555, 8'h10);
            else if (op == 2'd1) push_w(addr, 8'h30);
            else                 push_w(addr, 8'h50);
        end
        @(negedge clk);
        chk(req_ready && !busy, "R10", "idle before request", {req_ready, busy}, 2'b10);
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
        req_len_m1 = LW'(len_m1); poll_limit = TW'(limit);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy && !req_ready, "R10", "busy after accept", {busy, req_ready}, 2'b10);
        got_done = 1'b0;
        got_err = 1'b0;
        n = 0;
        while (!got_done && n < 30000) begin
            @(negedge clk);
            n++;
            if (done) begin
                got_done = 1'b1;
                got_err = err;
            end
        end
        chk(got_done, "R10", "done seen", got_done, 1);
        chk(got_err == exp_err, exp_err ? "R9" : "R10", "err flag", got_err, exp_err);
        chk(!busy, "R10", "busy low with done", busy, 0);
        chk(reads == exp_reads, (op == 2'd0) ? "R6" : "R7", "poll read count", reads, exp_reads);
        chk(consumed == exp_bytes, exp_err ? "R9" : "R8", "bytes taken", consumed, exp_bytes);
        chk(exp_a.size() == 0, tag, "writes left", exp_a.size(), 0);
        @(negedge clk);
        chk(!done, "R10", "done one cycle", done, 0);
        exp_a.delete();
        exp_d.delete();
        data_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fl_we_n && fl_oe_n && fl_ce_n, "R11", "strobes in reset", {fl_we_n, fl_oe_n, fl_ce_n}, 3'b111);
        chk(!fl_drive && !busy && !done, "R11", "idle outputs in reset", {fl_drive, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && !wr_ready, "R11", "ready after reset", {req_ready, wr_ready}, 2'b10);

        // R1 R6 R8: three bytes, data match after three busy reads each
        data_q = '{8'hA5, 8'h3C, 8'hFF};
        run_op(2'd0, 'h01230, 2, 0, 3, 100, 1'b0, 12, 3, "R1");
        // R6: one byte at the top address, device ready at once
        data_q = '{8'h12};
        run_op(2'd0, 'h3FFFF, 0, 0, 0, 100, 1'b0, 1, 1, "R1");
        // R6: bit 7 never matches, toggle stops
        data_q = '{8'h80, 8'h01};
        run_op(2'd0, 'h00100, 1, 1, 3, 100, 1'b0, 8, 2, "R1");
        // R2 R7: sector, block, chip erase
        run_op(2'd1, 'h05000, 0, 0, 4, 100, 1'b0, 5, 0, "R2");
        run_op(2'd2, 'h20000, 0, 1, 2, 100, 1'b0, 3, 0, "R2");
        run_op(2'd3, 'h00000, 0, 0, 1, 100, 1'b0, 2, 0, "R2");
        // R9: device never finishes, limit of five reads
        data_q = '{8'h55, 8'h66, 8'h77};
        run_op(2'd0, 'h00200, 2, 2, 0, 5, 1'b1, 5, 1, "R9");
        // recovery after an error
        data_q = '{8'h9A};
        run_op(2'd0, 'h00010, 0, 0, 2, 100, 1'b0, 3, 1, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule